// File: doc/BRIEF.md
# Radix-2 SRT Fractional Divider with Redundant Remainder

This block divides a normalised fractional dividend by a normalised fractional divisor, one quotient digit per clock. The partial remainder is held as two words, a sum word and a carry word, so an iteration has no carry propagation. Each cycle a small estimator adds the top bits of the two shifted words. It picks a signed quotient digit from {-1, 0, +1}, and a 3:2 compressor adds zero, the divisor, or the divisor's complement with a carry-in of one.

Positive and negative digits are gathered in two separate words. After the last iteration a single finishing cycle does three things: it resolves the remainder with a carry-propagate addition, corrects a negative remainder by adding the divisor back, and forms the two's-complement quotient as the difference of the two digit words, less one when a correction took place.

Operands are W-bit unsigned fractions (value = word / 2^W). A caller pulses start with a divisor whose top bit is set and a dividend smaller than the divisor. The results appear with a one-cycle done pulse.

Top module: `srt_divider`

## Requirements
- R1: While rst_n is low at a clock edge, done, quotient and remainder are all cleared to zero.
- R2: A start pulse seen at a rising edge while the block is idle is accepted. done is high for exactly one cycle, after the (W+1)-th rising edge that follows the accepting edge.
- R3: For a divisor D with bit W-1 set and a dividend Z < D, the results satisfy Z*2^W = Q*D + R with 0 <= R < D. Here Q is the quotient word and R is the remainder word, both read as unsigned integers.
- R4: start is ignored while a division is in progress. Neither the operands nor the result of the running division change, and no extra done pulse follows.
- R5: Throughout the iterations, the sum plus carry of the partial remainder, read as a signed fraction, stays within [-d, d), where d is the latched divisor.
- R6: No quotient position is marked both as a +1 digit and as a -1 digit.
- R7: quotient and remainder keep their values in every cycle in which done is low.
- R8: When the resolved final remainder is negative, the divisor is added to it and one unit in the last place is taken from the quotient. For example, a zero dividend returns Q = 0 and R = 0.
- R9: The extreme divisors 2^(W-1) and 2^W-1, and the largest legal dividend D-1, give exact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a division with the present operands |
| dividend | input | W | Unsigned fraction, must be below divisor |
| divisor | input | W | Unsigned fraction with top bit set |
| done | output | 1 | One-cycle pulse marking valid results |
| quotient | output | W | Quotient fraction, Q / 2^W |
| remainder | output | W | Final remainder word R |

## Verification
The checker evaluates four properties on every cycle: the redundant remainder stays inside [-d, d), the positive and negative digit words never overlap, the divisor stays latched while a run is in progress, and the outputs hold between results. It also checks the exact done latency, the single-cycle width of done, and that the remainder is below the divisor whenever done is high. Exact arithmetic correctness can only be shown by the bench's scenarios, which compare the quotient and remainder with integer division for random normalised operands and for the corner cases. The same applies to the correction path triggered by a zero dividend, the extreme divisors, and the start pulse that arrives mid-run and must be dropped.

// File: rtl/srt_div_pkg.sv
// Shared types for the radix-2 SRT divider.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package srt_div_pkg;

    // Controller phases: idle, iterating, resolving the result.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ITER   = 2'd1,
        ST_FINISH = 2'd2
    } srt_state_e;

    // Signed quotient digit: non0 = digit is +1 or -1, neg = digit is -1.
    typedef struct packed {
        logic non0;
        logic neg;
    } srt_digit_t;

endpackage

// File: rtl/srt_digit_sel.sv
// Quotient digit selection for radix-2 SRT.
// Adds the truncated top bits of the shifted sum and carry words
// (EST_W bits, two of them fractional, weight of LSB = 1/4) and
// maps the estimate t to a digit: t >= 0 -> +1, t in {-1/4,-1/2} -> 0,
// t <= -3/4 -> -1. Assumes EST_W >= 3 and two's-complement inputs.
module srt_digit_sel
    import srt_div_pkg::*;
#(
    parameter int EST_W = 5
) (
    input  logic [EST_W-1:0] sum_top,
    input  logic [EST_W-1:0] carry_top,
    output srt_digit_t       digit
);

    logic [EST_W-1:0] est;

    // Estimate of the shifted partial remainder, modulo 2^EST_W.
    always_comb begin
        est = sum_top + carry_top;
    end

    // Zero digit only for -1/4 and -1/2: all bits above the LSB are ones.
    always_comb begin
        digit.non0 = ~(&est[EST_W-1:1]);
        digit.neg  = est[EST_W-1];
    end

endmodule

// File: rtl/srt_csa_step.sv
// One radix-2 SRT iteration on a carry-save partial remainder.
// Inputs are the already shifted sum and carry words (2s). The digit
// selects 0, the divisor, or its complement with a carry-in of one;
// a 3:2 compressor yields the next sum and carry words. Words are
// W+3 bits: three integer bits (weights 4,2,1) and W fraction bits.
module srt_csa_step
    import srt_div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W+2:0] sum_sh,
    input  logic [W+2:0] carry_sh,
    input  logic [W-1:0] dvs,
    input  srt_digit_t   digit,
    output logic [W+2:0] sum_nxt,
    output logic [W+2:0] carry_nxt
);

    localparam int L = W + 3;

    logic [L-1:0] dext;
    logic [L-1:0] addend;
    logic         cin;
    logic [L-2:0] maj;

    // Divisor multiple: -1 adds d, +1 adds ~d plus one ulp, 0 adds nothing.
    always_comb begin
        dext   = {3'b000, dvs};
        cin    = digit.non0 & ~digit.neg;
        if (!digit.non0)
            addend = '0;
        else if (digit.neg)
            addend = dext;
        else
            addend = ~dext;
    end

    // 3:2 compression; the empty LSB of the carry word takes the carry-in.
    always_comb begin
        sum_nxt   = sum_sh ^ carry_sh ^ addend;
        maj       = (sum_sh[L-2:0] & carry_sh[L-2:0])
                  | (sum_sh[L-2:0] & addend[L-2:0])
                  | (carry_sh[L-2:0] & addend[L-2:0]);
        carry_nxt = {maj, cin};
    end

endmodule

// File: rtl/srt_resolve.sv
// Final conversion after the last iteration.
// Adds sum and carry words to get the signed remainder; if negative,
// adds the divisor back and subtracts one ulp from the quotient.
// Quotient = positive digit word - negative digit word - correction.
// Assumes the remainder lies in [-d, d), so the corrected value fits W bits.
module srt_resolve #(
    parameter int W = 16
) (
    input  logic [W+2:0] sum_w,
    input  logic [W+2:0] carry_w,
    input  logic [W-1:0] dvs,
    input  logic [W-1:0] pos_w,
    input  logic [W-1:0] neg_w,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);

    localparam int L = W + 3;

    logic [L-1:0] rsum;
    logic         rneg;
    logic [1:0]   hi_unused;

    // Carry-propagate addition of the redundant remainder.
    always_comb begin
        rsum      = sum_w + carry_w;
        rneg      = rsum[L-1];
        hi_unused = rsum[L-2:W];
    end

    // Sign correction of remainder and quotient.
    always_comb begin
        rem = rneg ? (rsum[W-1:0] + dvs) : rsum[W-1:0];
        quo = pos_w - neg_w - {{(W-1){1'b0}}, rneg};
    end

endmodule

// File: rtl/srt_divider.sv
// Radix-2 SRT fractional divider, one quotient digit per clock.
// Accepts start only when idle, runs W iterations on a carry-save
// remainder, resolves in one more cycle and pulses done.
// Assumes divisor[W-1] = 1 and dividend < divisor; W >= 3.
module srt_divider
    import srt_div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);

    localparam int L     = W + 3;
    localparam int EST_W = 5;
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    srt_state_e     state_q;
    logic [L-1:0]   sum_q;
    logic [L-1:0]   carry_q;
    logic [W-1:0]   pos_q;
    logic [W-1:0]   neg_q;
    logic [W-1:0]   dvs_q;
    logic [CNT_W-1:0] cnt_q;

    logic [L-1:0]   sum_sh;
    logic [L-1:0]   carry_sh;
    logic [L-1:0]   sum_nxt;
    logic [L-1:0]   carry_nxt;
    srt_digit_t     digit;
    logic [W-1:0]   quo_fin;
    logic [W-1:0]   rem_fin;

    // Doubling of the partial remainder: left shift of both words.
    always_comb begin
        sum_sh   = {sum_q[L-2:0], 1'b0};
        carry_sh = {carry_q[L-2:0], 1'b0};
    end

    srt_digit_sel #(.EST_W(EST_W)) u_sel (
        .sum_top   (sum_sh[L-1 -: EST_W]),
        .carry_top (carry_sh[L-1 -: EST_W]),
        .digit     (digit)
    );

    srt_csa_step #(.W(W)) u_step (
        .sum_sh    (sum_sh),
        .carry_sh  (carry_sh),
        .dvs       (dvs_q),
        .digit     (digit),
        .sum_nxt   (sum_nxt),
        .carry_nxt (carry_nxt)
    );

    srt_resolve #(.W(W)) u_res (
        .sum_w   (sum_q),
        .carry_w (carry_q),
        .dvs     (dvs_q),
        .pos_w   (pos_q),
        .neg_w   (neg_q),
        .quo     (quo_fin),
        .rem     (rem_fin)
    );

    // Controller, remainder and digit registers, and result outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sum_q     <= '0;
            carry_q   <= '0;
            pos_q     <= '0;
            neg_q     <= '0;
            dvs_q     <= '0;
            cnt_q     <= '0;
            done      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sum_q   <= {3'b000, dividend};
                        carry_q <= '0;
                        pos_q   <= '0;
                        neg_q   <= '0;
                        dvs_q   <= divisor;
                        cnt_q   <= '0;
                        state_q <= ST_ITER;
                    end
                end
                ST_ITER: begin
                    sum_q   <= sum_nxt;
                    carry_q <= carry_nxt;
                    pos_q   <= {pos_q[W-2:0], digit.non0 & ~digit.neg};
                    neg_q   <= {neg_q[W-2:0], digit.non0 & digit.neg};
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == LAST)
                        state_q <= ST_FINISH;
                end
                ST_FINISH: begin
                    quotient  <= quo_fin;
                    remainder <= rem_fin;
                    done      <= 1'b1;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/srt_divider_chk.sv
// Property checker for srt_divider, attached by bind below.
// Observes ports and internal registers; drives nothing into the design.
module srt_divider_chk
    import srt_div_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input srt_state_e   state_q,
    input logic [W+2:0] sum_q,
    input logic [W+2:0] carry_q,
    input logic [W-1:0] pos_q,
    input logic [W-1:0] neg_q,
    input logic [W-1:0] dvs_q
);

    localparam int L   = W + 3;
    localparam int LAT = W + 2;
    localparam int LW  = $clog2(W + 4) + 1;

    logic signed [L-1:0] pr_val;
    logic signed [L-1:0] d_pos;
    logic                running;
    logic [LW-1:0]       lat_q;

    // Signed value of the redundant remainder and the divisor bound.
    always_comb begin
        pr_val  = sum_q + carry_q;
        d_pos   = {3'b000, dvs_q};
        running = (state_q == ST_ITER) || (state_q == ST_FINISH);
    end

    // Cycles since an accepted start; cleared on done.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else if (state_q == ST_IDLE && start)
            lat_q <= LW'(1);
        else if (done)
            lat_q <= '0;
        else if (lat_q != '0)
            lat_q <= lat_q + 1'b1;
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LW'(LAT)));

    p_rem_below_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (remainder < dvs_q));

    p_busy_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start) |=> $stable(dvs_q));

    p_pr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ((pr_val < d_pos) && (pr_val >= -d_pos)));

    p_digit_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q & neg_q) == '0);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder)));

endmodule

bind srt_divider srt_divider_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .state_q   (state_q),
    .sum_q     (sum_q),
    .carry_q   (carry_q),
    .pos_q     (pos_q),
    .neg_q     (neg_q),
    .dvs_q     (dvs_q)
);

// File: tb/srt_divider_test.sv
`timescale 1ns/1ps
// Self-checking bench for srt_divider: directed corners plus seeded
// random normalised operands, compared with integer division.
module srt_divider_test;

    localparam int W = 16;

    logic         clk;
    logic         rst_n;
    logic         start;
    logic [W-1:0] dividend;
    logic [W-1:0] divisor;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;

    int checks = 0;
    int fails  = 0;

    srt_divider #(.W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder)
    );

    // 200 MHz clock.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Record one check and report a mismatch.
    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected quotient of Z*2^W / D.
    function automatic logic [63:0] exp_quo(input logic [W-1:0] z, input logic [W-1:0] d);
        return (64'(z) << W) / 64'(d);
    endfunction

    // Expected remainder of Z*2^W / D.
    function automatic logic [63:0] exp_rem(input logic [W-1:0] z, input logic [W-1:0] d);
        return (64'(z) << W) % 64'(d);
    endfunction

    // Run one division; optionally pulse start mid-run with other operands.
    task automatic run_one(input logic [W-1:0] z, input logic [W-1:0] d,
                           input string req, input bit inject);
        int lat;
        @(negedge clk);
        start = 1'b1; dividend = z; divisor = d;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (inject && lat == 4) begin
                start = 1'b1; dividend = ~z; divisor = {1'b1, ~d[W-2:0]};
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(lat == W + 2, "R2 latency", 64'(lat), 64'(W + 2));
        check(64'(quotient) == exp_quo(z, d), {req, " quotient"}, 64'(quotient), exp_quo(z, d));
        check(64'(remainder) == exp_rem(z, d), {req, " remainder"}, 64'(remainder), exp_rem(z, d));
        if (inject) begin
            int extra = 0;
            for (int i = 0; i < W + 4; i++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check(extra == 0, "R4 no extra done", 64'(extra), 64'd0);
            check(64'(quotient) == exp_quo(z, d), "R4 result kept", 64'(quotient), exp_quo(z, d));
        end
    endtask

    // Global watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    // Main sequence.
    initial begin
        logic [W-1:0] q_hold;
        logic [W-1:0] r_hold;
        logic [W-1:0] rd;
        logic [W-1:0] rz;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; dividend = '0; divisor = '0;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done", 64'(done), 64'd0);
        check(quotient == '0, "R1 quotient", 64'(quotient), 64'd0);
        check(remainder == '0, "R1 remainder", 64'(remainder), 64'd0);
        rst_n = 1'b1;

        // R8: zero dividend forces a negative final remainder and correction.
        run_one('0, 16'hC000, "R8 zero dividend", 1'b0);
        // R9: extreme divisors and largest legal dividend.
        run_one(16'h7FFF, 16'h8000, "R9 min divisor", 1'b0);
        run_one(16'hFFFE, 16'hFFFF, "R9 max divisor", 1'b0);
        run_one(16'h0001, 16'hFFFF, "R9 tiny dividend", 1'b0);
        run_one(16'h4000, 16'h8000, "R3 exact half", 1'b0);
        run_one(16'h5555, 16'hAAAB, "R3 alternating", 1'b0);

        // R4: start pulse during a run is dropped.
        run_one(16'h1234, 16'h9ABC, "R4 busy start", 1'b1);

        // R7: outputs hold while done is low.
        q_hold = quotient; r_hold = remainder;
        repeat (5) @(negedge clk);
        check(quotient == q_hold, "R7 quotient hold", 64'(quotient), 64'(q_hold));
        check(remainder == r_hold, "R7 remainder hold", 64'(remainder), 64'(r_hold));

        // R3: random normalised operands.
        for (int n = 0; n < 150; n++) begin
            rd = {1'b1, 15'($urandom)};
            rz = W'($urandom % 32'(rd));
            run_one(rz, rd, "R3 random", 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule